// File: doc/BRIEF.md
# Interrupt-capable GPIO controller

A register-mapped general-purpose I/O block for up to 32 pins. It sits behind a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Software sets per-pin input enables, output enables, output values and an output inversion mask. The block drives each pad's output value and output-enable lines. Pad inputs pass through a two-flop synchroniser before any use.

Every pin can flag four trigger classes: rising edge, falling edge, high level and low level. Each class has its own per-pin enable register and its own sticky pending register. Software clears pending bits by writing ones. A pending bit records its condition whatever the enable says. Each pin has a dedicated interrupt line, raised while any class is both pending and enabled for that pin. The bus and the pad pins are plain control signals, so no flow control is involved.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset every register reads 0, and `pin_oe`, `pin_out` and `pin_irq` are all 0.
- R2: Registers sit at fixed byte offsets: input value 0x00, input enable 0x04, output enable 0x08, output value 0x0C, output inversion 0x40. For trigger class k (rise=0, fall=1, high=2, low=3), the enable register is at 0x18+8k and the pending register at 0x1C+8k. Pin i uses bit i. Writable registers read back what was written, and an unmapped offset such as 0x10 reads 0.
- R3: Offset 0x00 returns the synchronised pad value ANDed with the input enable, so a disabled pin reads 0. A pad change becomes visible in the second clock edge after it occurs. Writes to 0x00 have no effect.
- R4: `pin_out` equals output value XOR output inversion, and `pin_oe` equals the output enable register. Reading 0x0C returns the stored output value and not the inverted pin value.
- R5: A 0-to-1 change of an enabled, synchronised input sets the rise pending bit one clock edge after the new value becomes readable at 0x00.
- R6: A 1-to-0 change of an enabled, synchronised input sets the fall pending bit with the same timing as R5.
- R7: The high and low classes set their pending bit on every cycle the enabled input is high or low. A pin whose input enable is clear raises neither level class.
- R8: Pending bits are sticky. They stay set after the condition ends until they are cleared.
- R9: Writing 1 to a pending bit clears it. Writing 0 leaves the bit unchanged.
- R10: If a condition is detected in the same cycle as a clearing write to its pending bit, the bit stays set.
- R11: Pending bits set regardless of their enable. `pin_irq[i]` is 1 exactly when, for some class, both the pending bit and the enable bit of pin i are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Raw pad input values |
| pin_out | output | NPINS | Pad output values after inversion |
| pin_oe | output | NPINS | Pad output enables |
| pin_irq | output | NPINS | Per-pin interrupt lines |

## Verification
Edges are driven on some pins with the enable set and on others with it clear. This shows that pending sets regardless of enable, while the interrupt line follows enable AND pending. A held-high pin shows that a level condition persists against a clear, and so separates the level classes from the edge classes. Releasing the pin then shows stickiness and write-one-to-clear. A clearing write timed onto the exact edge where a rise is recorded shows the set-over-clear priority. Sampling cycle by cycle after a pad change pins the synchroniser latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W = 32;
  localparam int NCLS  = 4;

  typedef enum logic [1:0] {
    CLS_RISE = 2'd0,
    CLS_FALL = 2'd1,
    CLS_HIGH = 2'd2,
    CLS_LOW  = 2'd3
  } trig_cls_e;

  localparam int OFS_INVAL = 'h00;
  localparam int OFS_INEN  = 'h04;
  localparam int OFS_OUTEN = 'h08;
  localparam int OFS_OUTV  = 'h0C;
  localparam int OFS_INV   = 'h40;
  localparam int OFS_CLS0  = 'h18;
  localparam int CLS_STEP  = 8;

  function automatic int en_ofs(input int cls);
    return OFS_CLS0 + CLS_STEP * cls;
  endfunction

  function automatic int pend_ofs(input int cls);
    return OFS_CLS0 + CLS_STEP * cls + 4;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             sync_q,
  input  logic [W-1:0]             in_en,
  output logic [W-1:0]             in_val,
  output logic [NCLS-1:0][W-1:0]   cond
);

  logic [W-1:0] prev_q;

  assign in_val = sync_q & in_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= in_val;
  end

  always_comb begin
    cond           = '0;
    cond[CLS_RISE] = in_val & ~prev_q;
    cond[CLS_FALL] = ~in_val & prev_q & in_en;
    cond[CLS_HIGH] = in_val;
    cond[CLS_LOW]  = ~sync_q & in_en;
  end

endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int W      = 32,
  parameter int AW     = 8,
  parameter int EN_OFS = 'h18,
  parameter int PD_OFS = 'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  cond,
  output logic [W-1:0]  en_q,
  output logic [W-1:0]  pend_q
);

  logic         en_hit;
  logic [W-1:0] clr_mask;

  assign en_hit   = bus_we && (bus_addr == AW'(EN_OFS));
  assign clr_mask = (bus_we && (bus_addr == AW'(PD_OFS))) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_hit) en_q <= wdata;
      pend_q <= (pend_q & ~clr_mask) | cond;
    end
  end

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_irq
);

  logic [NPINS-1:0]            wdata_w;
  logic [NPINS-1:0]            ie_q, oe_q, outv_q, inv_q;
  logic [NPINS-1:0]            sync_q, in_val;
  logic [NCLS-1:0][NPINS-1:0]  cond, en_q, pend_q;

  assign wdata_w = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      oe_q   <= '0;
      outv_q <= '0;
      inv_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(OFS_INEN))  ie_q   <= wdata_w;
      if (bus_addr == AW'(OFS_OUTEN)) oe_q   <= wdata_w;
      if (bus_addr == AW'(OFS_OUTV))  outv_q <= wdata_w;
      if (bus_addr == AW'(OFS_INV))   inv_q  <= wdata_w;
    end
  end

  gpio_in_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  gpio_trig_detect #(.W(NPINS)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_q (sync_q),
    .in_en  (ie_q),
    .in_val (in_val),
    .cond   (cond)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    gpio_pend_bank #(
      .W      (NPINS),
      .AW     (AW),
      .EN_OFS (en_ofs(c)),
      .PD_OFS (pend_ofs(c))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .wdata    (wdata_w),
      .cond     (cond[c]),
      .en_q     (en_q[c]),
      .pend_q   (pend_q[c])
    );
  end

  always_comb begin
    pin_irq = '0;
    for (int c = 0; c < NCLS; c++) begin
      pin_irq = pin_irq | (pend_q[c] & en_q[c]);
    end
  end

  assign pin_out = outv_q ^ inv_q;
  assign pin_oe  = oe_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_INVAL)) bus_rdata = REG_W'(in_val);
    if (bus_addr == AW'(OFS_INEN))  bus_rdata = REG_W'(ie_q);
    if (bus_addr == AW'(OFS_OUTEN)) bus_rdata = REG_W'(oe_q);
    if (bus_addr == AW'(OFS_OUTV))  bus_rdata = REG_W'(outv_q);
    if (bus_addr == AW'(OFS_INV))   bus_rdata = REG_W'(inv_q);
    for (int c = 0; c < NCLS; c++) begin
      if (bus_addr == AW'(en_ofs(c)))   bus_rdata = REG_W'(en_q[c]);
      if (bus_addr == AW'(pend_ofs(c))) bus_rdata = REG_W'(pend_q[c]);
    end
  end

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_we,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [W-1:0]           ie_q,
  input logic [W-1:0]           pin_oe,
  input logic [W-1:0]           pin_irq,
  input logic [NCLS-1:0][W-1:0] cond,
  input logic [NCLS-1:0][W-1:0] en,
  input logic [NCLS-1:0][W-1:0] pend
);

  logic [W-1:0] en_any;
  assign en_any = en[0] | en[1] | en[2] | en[3];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_irq == '0)); // R1

  AST_INPUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_INVAL)) |-> ((bus_rdata[W-1:0] & ~ie_q) == '0)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_irq & ~en_any) == '0)); // R11

  for (genvar c = 0; c < NCLS; c++) begin : g_chk
    logic [W-1:0] clr;
    assign clr = (bus_we && bus_addr == AW'(pend_ofs(c))) ? bus_wdata[W-1:0] : '0;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend[c] & ~clr) != '0) |=>
        ((pend[c] & $past(pend[c] & ~clr)) == $past(pend[c] & ~clr))); // R8

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~cond[c]) != '0) |=> ((pend[c] & $past(clr & ~cond[c])) == '0)); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[c] != '0) |=> ((pend[c] & $past(cond[c])) == $past(cond[c]))); // R10
  end

endmodule

bind gpio_irq_top gpio_irq_chk #(.W(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ie_q      (ie_q),
  .pin_oe    (pin_oe),
  .pin_irq   (pin_irq),
  .cond      (cond),
  .en        (en_q),
  .pend      (pend_q)
);

// File: tb/gpio_irq_top_bench.sv
module gpio_irq_top_bench;

  localparam int NP = 32;

  localparam logic [7:0] A_IN   = 8'h00, A_IE = 8'h04, A_OE = 8'h08, A_OV = 8'h0C;
  localparam logic [7:0] A_REN  = 8'h18, A_RPD = 8'h1C, A_FEN = 8'h20, A_FPD = 8'h24;
  localparam logic [7:0] A_HEN  = 8'h28, A_HPD = 8'h2C, A_LEN = 8'h30, A_LPD = 8'h34;
  localparam logic [7:0] A_INV  = 8'h40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_irq;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_irq_top #(.NPINS(NP), .AW(8)) u_gpio_irq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_irq   (pin_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic look(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [7:0] regs [13] = '{A_IN, A_IE, A_OE, A_OV, A_REN, A_RPD, A_FEN,
                              A_FPD, A_HEN, A_HPD, A_LEN, A_LPD, A_INV};
    @(negedge clk);
    foreach (regs[i]) begin
      look(regs[i], v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 pin_oe after reset", pin_oe, 32'h0);
    check("R1 pin_out after reset", pin_out, 32'h0);
    check("R1 pin_irq after reset", pin_irq, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_OE, 32'h1357_9BDF);
    wr(A_REN, 32'h0F0F_0001);
    wr(A_LEN, 32'h8000_0002);
    wr(A_INV, 32'hDEAD_BEEF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(A_IN, 32'hFFFF_FFFF);
    @(negedge clk);
    look(A_OE, v);  check("R2 output enable readback", v, 32'h1357_9BDF);
    look(A_REN, v); check("R2 rise enable readback", v, 32'h0F0F_0001);
    look(A_LEN, v); check("R2 low enable readback", v, 32'h8000_0002);
    look(A_INV, v); check("R2 inversion readback", v, 32'hDEAD_BEEF);
    look(A_FEN, v); check("R2 fall enable untouched", v, 32'h0);
    look(8'h10, v); check("R2 unmapped offset reads 0", v, 32'h0);
    look(A_IN, v);  check("R3 write to input value ignored", v, 32'h0);
    look(A_IE, v);  check("R3 input enable untouched by 0x00 write", v, 32'h0);
    wr(A_OE, 0); wr(A_REN, 0); wr(A_LEN, 0); wr(A_INV, 0);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(A_OV, 32'hF0F0_1234);
    wr(A_INV, 32'h0000_FFFF);
    wr(A_OE, 32'h00FF_00FF);
    @(negedge clk);
    check("R4 pin_out is value xor inversion", pin_out, 32'hF0F0_EDCB);
    check("R4 pin_oe follows enable", pin_oe, 32'h00FF_00FF);
    look(A_OV, v);
    check("R4 output value reads stored value", v, 32'hF0F0_1234);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pin_in = 32'hA5A5_5A5A;
    idle(4);
    look(A_IN, v); check("R3 disabled inputs read 0", v, 32'h0);
    wr(A_IE, 32'hFFFF_0000);
    look(A_IN, v); check("R3 partly enabled input", v, 32'hA5A5_0000);
    wr(A_IE, 32'hFFFF_FFFF);
    pin_in = 32'h0000_00FF;
    look(A_IN, v); check("R3 no change at edge 0", v, 32'hA5A5_5A5A);
    @(negedge clk);
    look(A_IN, v); check("R3 no change after one edge", v, 32'hA5A5_5A5A);
    @(negedge clk);
    look(A_IN, v); check("R3 new value after two edges", v, 32'h0000_00FF);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    pin_in = '0;
    idle(4);
    wr(A_RPD, 32'hFFFF_FFFF);
    wr(A_FPD, 32'hFFFF_FFFF);
    wr(A_REN, 32'h0000_0020);
    pin_in = 32'h0000_0220;
    @(negedge clk);
    @(negedge clk);
    look(A_RPD, v); check("R5 rise pending not yet set", v, 32'h0);
    @(negedge clk);
    look(A_RPD, v); check("R5 rise pending set", v, 32'h0000_0220);
    check("R11 irq only for enabled pin", pin_irq, 32'h0000_0020);
    pin_in = '0;
    idle(4);
    look(A_RPD, v); check("R8 rise pending sticky", v, 32'h0000_0220);
    look(A_FPD, v); check("R6 fall pending set", v, 32'h0000_0220);
    wr(A_RPD, 32'h0000_0020);
    look(A_RPD, v); check("R9 write 1 clears", v, 32'h0000_0200);
    check("R11 irq drops after clear", pin_irq, 32'h0);
    wr(A_RPD, 32'h0);
    look(A_RPD, v); check("R9 write 0 no effect", v, 32'h0000_0200);
    wr(A_REN, 32'h0000_0200);
    check("R11 late enable raises irq", pin_irq, 32'h0000_0200);
    wr(A_REN, 0);
    wr(A_RPD, 32'hFFFF_FFFF);
    wr(A_FPD, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pin_in = 32'h0000_0080;
    @(negedge clk);
    @(negedge clk);
    addr = A_RPD; we = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    we = 1'b0;
    look(A_RPD, v); check("R10 set wins over clear", v, 32'h0000_0080);
    wr(A_RPD, 32'hFFFF_FFFF);
    look(A_RPD, v); check("R9 clear after edge passed", v, 32'h0);
    pin_in = '0;
    idle(4);
    wr(A_FPD, 32'hFFFF_FFFF);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    wr(A_HEN, 32'h0000_0004);
    pin_in = 32'h0000_0004;
    idle(4);
    wr(A_HPD, 32'hFFFF_FFFF);
    look(A_HPD, v); check("R7 high level persists against clear", v, 32'h0000_0004);
    check("R11 irq from high class", pin_irq, 32'h0000_0004);
    pin_in = '0;
    idle(4);
    look(A_HPD, v); check("R8 high pending sticky", v, 32'h0000_0004);
    wr(A_HPD, 32'hFFFF_FFFF);
    look(A_HPD, v); check("R9 high pending cleared", v, 32'h0);
    check("R11 irq clear", pin_irq, 32'h0);
    wr(A_LPD, 32'hFFFF_FFFF);
    look(A_LPD, v); check("R7 low level all enabled pins", v, 32'hFFFF_FFFF);
    wr(A_IE, 32'hFFFF_0000);
    wr(A_LPD, 32'hFFFF_FFFF);
    look(A_LPD, v); check("R7 disabled pins raise no low", v, 32'hFFFF_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_output();
    t_input();
    t_edges();
    t_race();
    t_levels();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule